// File: doc/BRIEF.md
# Prediction-Directed Coefficient Scan Reorderer

This block sits between a quantizer and a run-length coder in a video texture pipeline. It takes the 64 quantized coefficients of one 8x8 transform block in raster order (row by row, position = row*8 + column) and sends them on in one of three scan orders. Which order is used is decided per block by two sideband inputs that travel with the first coefficient: whether AC prediction is on, and which neighbour the prediction came from. No register or software setting is involved.

Two 64-entry block stores alternate. One block fills in raster order while the other is read out through the scan-order lookup, so the reordering happens on the way out. With the output always ready, the block takes and emits one coefficient per cycle without a gap between blocks.

Both streams are valid/ready. An input beat transfers on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while both stores hold a complete block that has not been fully read out. An output beat transfers when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_coef` and `out_last` hold their values.

Top module: `coef_scan_reorder`

## Requirements
- R1: After a synchronous active-low reset, `in_ready` is 1 and `out_valid` is 0.
- R2: With `in_ac_pred` = 0 on the first beat, output k is the input at the k-th position of the classic zigzag. The zigzag walks the anti-diagonals and changes direction on each one: raster positions 0, 1, 8, 16, 9, 2, 3, 10, ...
- R3: With `in_ac_pred` = 1 and `in_pred_dir` = 0 (prediction from the left neighbour) on the first beat, the alternate-vertical order is used: raster positions 0, 8, 16, 24, 1, 9, 2, 10, 17, 25, 32, 40, ...
- R4: With `in_ac_pred` = 1 and `in_pred_dir` = 1 (prediction from the neighbour above) on the first beat, the alternate-horizontal order is used. This is the R3 order with row and column swapped: 0, 1, 2, 3, 8, 9, 16, 17, 10, 11, ...
- R5: The scan choice is taken only from the sideband on the first beat of a block. The sideband values on beats 2 to 64 have no effect on the output order.
- R6: `out_last` is 1 on the 64th output beat of every block and 0 on every other valid beat.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_coef` and `out_last` stay unchanged into the next cycle.
- R8: With `out_ready` held at 1, blocks sent back to back are all accepted at one coefficient per cycle, and `in_ready` never drops.
- R9: `in_ready` goes low only when more than 64 accepted coefficients are still unread. In that state both stores hold a full block.
- R10: When the stores are empty, the first coefficient of a block is presented on `out_valid` in the cycle right after its 64th input beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input coefficient valid |
| in_ready | output | 1 | Block can accept a coefficient |
| in_coef | input | COEF_W | Signed quantized coefficient, raster order |
| in_ac_pred | input | 1 | AC prediction enabled (sampled on first beat) |
| in_pred_dir | input | 1 | 0 = predicted from left, 1 = from above (sampled on first beat) |
| out_valid | output | 1 | Output coefficient valid |
| out_ready | input | 1 | Downstream accepts a coefficient |
| out_coef | output | COEF_W | Signed coefficient, scan order |
| out_last | output | 1 | Marks the 64th coefficient of a block |

## Verification
Every input position carries a distinct value, so a wrong entry in any of the three orders, or a swap of left and above, shows up as a mismatch at the exact output index. Sideband bits are inverted on all beats after the first. A design that sampled them late would switch tables partway through a block. The output is back-pressured at random and also held off entirely while two blocks are loaded. This catches a store that drops `in_ready` too early or too late, output data that moves during a stall, and a misplaced last flag. A back-to-back run with the output always ready exposes any bubble when the design switches between stores.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int SIDE  = 8;
  localparam int NCOEF = SIDE * SIDE;
  localparam int IDX_W = $clog2(NCOEF);
  localparam int HALF  = IDX_W / 2;

  typedef logic [IDX_W-1:0] cidx_t;

  typedef enum logic [1:0] {
    SCAN_ZIGZAG   = 2'd0,
    SCAN_ALT_VERT = 2'd1,
    SCAN_ALT_HORZ = 2'd2
  } scan_mode_e;

  // alternate-vertical order as raster positions
  localparam cidx_t ALT_V [NCOEF] = '{
     0,  8, 16, 24,  1,  9,  2, 10, 17, 25, 32, 40, 48, 56, 57, 49,
    41, 33, 26, 18,  3, 11,  4, 12, 19, 27, 34, 42, 50, 58, 35, 43,
    51, 59, 20, 28,  5, 13,  6, 14, 21, 29, 36, 44, 52, 60, 37, 45,
    53, 61, 22, 30,  7, 15, 23, 31, 38, 46, 54, 62, 39, 47, 55, 63
  };

  // raster position of the k-th zigzag element, walked diagonal by diagonal
  function automatic cidx_t zigzag_at(input int k);
    int n, lo, hi, r;
    cidx_t res;
    n   = 0;
    res = '0;
    for (int s = 0; s < 2*SIDE-1; s++) begin
      lo = (s > SIDE-1) ? s - (SIDE-1) : 0;
      hi = (s < SIDE-1) ? s : SIDE-1;
      for (int i = 0; i < SIDE; i++) begin
        if (lo + i <= hi) begin
          r = (s % 2 == 0) ? hi - i : lo + i;
          if (n == k) res = cidx_t'(r * SIDE + (s - r));
          n++;
        end
      end
    end
    return res;
  endfunction

  function automatic scan_mode_e pick_scan(input logic ac_on, input logic from_above);
    if (!ac_on) return SCAN_ZIGZAG;
    return from_above ? SCAN_ALT_HORZ : SCAN_ALT_VERT;
  endfunction
endpackage

// File: rtl/scan_order_rom.sv
module scan_order_rom
  import scan_pkg::*;
(
  input  scan_mode_e mode,
  input  cidx_t      idx,
  output cidx_t      pos
);
  cidx_t zz_tab [NCOEF];
  cidx_t av_tab [NCOEF];
  cidx_t ah_tab [NCOEF];

  for (genvar g = 0; g < NCOEF; g++) begin : g_tab
    assign zz_tab[g] = zigzag_at(g);
    assign av_tab[g] = ALT_V[g];
    // transpose: swap row and column fields
    assign ah_tab[g] = {ALT_V[g][HALF-1:0], ALT_V[g][IDX_W-1:HALF]};
  end

  always_comb begin
    unique case (mode)
      SCAN_ALT_VERT: pos = av_tab[idx];
      SCAN_ALT_HORZ: pos = ah_tab[idx];
      default:       pos = zz_tab[idx];
    endcase
  end
endmodule

// File: rtl/coef_pingpong_store.sv
module coef_pingpong_store
  import scan_pkg::*;
#(
  parameter int COEF_W = 12,
  parameter int NBANK  = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  cidx_t             wr_addr,
  input  logic [COEF_W-1:0] wr_data,
  input  logic              rd_bank,
  input  cidx_t             rd_addr,
  output logic [COEF_W-1:0] rd_data
);
  logic [COEF_W-1:0] bank_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [COEF_W-1:0] cells [NCOEF];
    always_ff @(posedge clk) begin
      if (wr_en && wr_bank == 1'(b)) cells[wr_addr] <= wr_data;
    end
    assign bank_q[b] = cells[rd_addr];
  end

  assign rd_data = bank_q[rd_bank];
endmodule

// File: rtl/coef_scan_reorder.sv
module coef_scan_reorder
  import scan_pkg::*;
#(
  parameter int COEF_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [COEF_W-1:0] in_coef,
  input  logic              in_ac_pred,
  input  logic              in_pred_dir,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [COEF_W-1:0] out_coef,
  output logic              out_last
);
  localparam cidx_t LAST_IDX = cidx_t'(NCOEF - 1);

  logic       wr_bank, rd_bank;
  cidx_t      wr_cnt, rd_cnt, rd_pos;
  logic [1:0] full;
  scan_mode_e mode_q [2];
  logic       in_fire, out_fire;

  assign in_ready  = !full[wr_bank];
  assign out_valid = full[rd_bank];
  assign out_last  = out_valid && (rd_cnt == LAST_IDX);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_bank   <= 1'b0;
      rd_bank   <= 1'b0;
      wr_cnt    <= '0;
      rd_cnt    <= '0;
      full      <= '0;
      mode_q[0] <= SCAN_ZIGZAG;
      mode_q[1] <= SCAN_ZIGZAG;
    end else begin
      if (in_fire) begin
        wr_cnt <= wr_cnt + 1'b1;
        if (wr_cnt == '0) mode_q[wr_bank] <= pick_scan(in_ac_pred, in_pred_dir);
        if (wr_cnt == LAST_IDX) begin
          full[wr_bank] <= 1'b1;
          wr_bank       <= ~wr_bank;
        end
      end
      if (out_fire) begin
        rd_cnt <= rd_cnt + 1'b1;
        if (rd_cnt == LAST_IDX) begin
          full[rd_bank] <= 1'b0;
          rd_bank       <= ~rd_bank;
        end
      end
    end
  end

  scan_order_rom u_rom (
    .mode (mode_q[rd_bank]),
    .idx  (rd_cnt),
    .pos  (rd_pos)
  );

  coef_pingpong_store #(.COEF_W(COEF_W), .NBANK(2)) u_store (
    .clk     (clk),
    .wr_en   (in_fire),
    .wr_bank (wr_bank),
    .wr_addr (wr_cnt),
    .wr_data (in_coef),
    .rd_bank (rd_bank),
    .rd_addr (rd_pos),
    .rd_data (out_coef)
  );
endmodule

// File: rtl/coef_scan_reorder_chk.sv
module coef_scan_reorder_chk #(
  parameter int COEF_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [COEF_W-1:0] out_coef,
  input logic              out_last
);
  int unsigned held;
  int unsigned out_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held    <= 0;
      out_idx <= 0;
    end else begin
      held <= held + ((in_valid && in_ready) ? 1 : 0) - ((out_valid && out_ready) ? 1 : 0);
      if (out_valid && out_ready) out_idx <= (out_idx == 63) ? 0 : out_idx + 1;
    end
  end

  // R6
  last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> out_idx == 63);
  // R6
  last_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx == 63) |-> out_last);
  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_coef) && $stable(out_last)));
  // R9
  stall_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> held > 64);
  // R9
  no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held <= 128);
endmodule

bind coef_scan_reorder coef_scan_reorder_chk #(.COEF_W(COEF_W)) u_chk (.*);

// File: tb/coef_scan_reorder_bench.sv
module coef_scan_reorder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ac_pred = 1'b0, in_pred_dir = 1'b0;
  logic [W-1:0] in_coef = '0;
  logic out_ready = 1'b0;
  wire  in_ready, out_valid, out_last;
  wire  [W-1:0] out_coef;

  int checks = 0, failures = 0, stalls = 0;
  bit hold_off = 1'b0, rand_ready = 1'b0;

  logic [W-1:0] q_coef [$];
  bit           q_last [$];
  int           q_mode [$];
  string        mode_req [3] = '{"R2", "R3", "R4"};

  bit           prev_stall = 1'b0;
  logic [W-1:0] prev_coef;
  bit           prev_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  coef_scan_reorder #(.COEF_W(W)) u_coef_scan_reorder (
    .clk, .rst_n, .in_valid, .in_ready, .in_coef, .in_ac_pred, .in_pred_dir,
    .out_valid, .out_ready, .out_coef, .out_last
  );

  int zz_ref [64] = '{
     0,  1,  8, 16,  9,  2,  3, 10, 17, 24, 32, 25, 18, 11,  4,  5,
    12, 19, 26, 33, 40, 48, 41, 34, 27, 20, 13,  6,  7, 14, 21, 28,
    35, 42, 49, 56, 57, 50, 43, 36, 29, 22, 15, 23, 30, 37, 44, 51,
    58, 59, 52, 45, 38, 31, 39, 46, 53, 60, 61, 54, 47, 55, 62, 63};
  int av_ref [64] = '{
     0,  8, 16, 24,  1,  9,  2, 10, 17, 25, 32, 40, 48, 56, 57, 49,
    41, 33, 26, 18,  3, 11,  4, 12, 19, 27, 34, 42, 50, 58, 35, 43,
    51, 59, 20, 28,  5, 13,  6, 14, 21, 29, 36, 44, 52, 60, 37, 45,
    53, 61, 22, 30,  7, 15, 23, 31, 38, 46, 54, 62, 39, 47, 55, 63};

  function automatic int ref_pos(int mode, int k);
    if (mode == 0) return zz_ref[k];
    if (mode == 1) return av_ref[k];
    return (av_ref[k] % 8) * 8 + av_ref[k] / 8;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: called at a falling edge, returns at the falling edge after the last accept
  task automatic send_block(bit ac, bit dir, int seed, bit scramble);
    logic [W-1:0] blk [64];
    int mode;
    mode = !ac ? 0 : (dir ? 2 : 1);
    for (int p = 0; p < 64; p++) blk[p] = W'(((seed * 67 + p * 13) % 4096) - 2048);
    for (int k = 0; k < 64; k++) begin
      q_coef.push_back(blk[ref_pos(mode, k)]);
      q_last.push_back(k == 63);
      q_mode.push_back(mode);
    end
    for (int k = 0; k < 64; k++) begin
      in_valid    = 1'b1;
      in_coef     = blk[k];
      in_ac_pred  = (k > 0 && scramble) ? ~ac  : ac;   // R5: later beats carry wrong sideband
      in_pred_dir = (k > 0 && scramble) ? ~dir : dir;
      while (!in_ready) begin stalls++; @(negedge clk); end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    out_ready = hold_off ? 1'b0 : (rand_ready ? ($urandom % 4 != 0) : 1'b1);
    if (rst_n) begin
      if (prev_stall)  // R7
        check(out_valid && out_coef == prev_coef && out_last == prev_last, "R7",
              "held output changed", int'(out_coef), int'(prev_coef));
      if (out_valid && out_ready) begin
        if (q_coef.size() == 0) begin
          check(1'b0, "R6", "unexpected output beat", int'(out_coef), 0);
        end else begin
          logic [W-1:0] ec;
          bit el;
          int em;
          ec = q_coef.pop_front(); el = q_last.pop_front(); em = q_mode.pop_front();
          check(out_coef == ec, mode_req[em], "scan order coef", int'($signed(out_coef)), int'($signed(ec)));
          check(out_last == el, "R6", "last flag", int'(out_last), int'(el));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_coef  = out_coef;
      prev_last  = out_last;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", q_coef.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int wait_cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    // R2 with R10 latency from empty stores
    send_block(1'b0, 1'b0, 1, 1'b0);
    check(out_valid == 1'b1, "R10", "first output one cycle after block", int'(out_valid), 1);
    repeat (70) @(negedge clk);
    // R3, R4 with scrambled later sideband (R5)
    send_block(1'b1, 1'b0, 2, 1'b1);
    repeat (70) @(negedge clk);
    send_block(1'b1, 1'b1, 3, 1'b1);
    repeat (70) @(negedge clk);
    send_block(1'b0, 1'b1, 4, 1'b1);
    repeat (70) @(negedge clk);

    // R8: back to back with output always ready
    stalls = 0;
    send_block(1'b1, 1'b1, 5, 1'b0);
    send_block(1'b0, 1'b0, 6, 1'b0);
    send_block(1'b1, 1'b0, 7, 1'b0);
    send_block(1'b1, 1'b1, 8, 1'b0);
    check(stalls == 0, "R8", "input stalls in streaming", stalls, 0);
    repeat (70) @(negedge clk);

    // R9: output held off, two blocks fill both stores
    hold_off = 1'b1;
    @(negedge clk);
    stalls = 0;
    send_block(1'b1, 1'b0, 9, 1'b0);
    send_block(1'b0, 1'b0, 10, 1'b0);
    check(stalls == 0, "R9", "stalls while a store was free", stalls, 0);
    check(in_ready == 1'b0, "R9", "in_ready with both stores full", int'(in_ready), 0);
    check(out_valid == 1'b1, "R9", "out_valid with both stores full", int'(out_valid), 1);
    repeat (5) @(negedge clk);
    check(in_ready == 1'b0, "R9", "in_ready stays low while held", int'(in_ready), 0);

    // random back-pressure
    hold_off   = 1'b0;
    rand_ready = 1'b1;
    send_block(1'b1, 1'b1, 11, 1'b1);
    send_block(1'b1, 1'b0, 12, 1'b0);
    send_block(1'b0, 1'b1, 13, 1'b1);

    wait_cnt = 0;
    while (q_coef.size() != 0 && wait_cnt < 2000) begin @(negedge clk); wait_cnt++; end
    check(q_coef.size() == 0, "R6", "all expected beats emitted", q_coef.size(), 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R6", "no output after drain", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9", "in_ready after drain", int'(in_ready), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule